// File: doc/BRIEF.md
# Flash Self-Programming Controller with Unlock

This block lets software running on the chip change its own program flash. Software fills a 64-word holding buffer one word at a time. It then writes two key bytes in a fixed order and sets the start bit in the control register. The controller then runs one of three operations: copy the whole buffer into one flash row, program a single flash word, or erase one page of eight rows. The start bit reads back as set for the whole operation, which lasts a fixed number of cycles. When the count expires the bit clears itself.

A start that does not follow a valid unlock is dropped, and a sticky error bit is set. While an operation runs, the block ignores writes to the buffer, the key register and the control register. The flash array is modelled inside the block as a register memory with a program port, a page-erase port and a read port with one cycle of latency.

Top module: `nvm_selfprog_ctrl`

## Requirements
- R1: After reset, `busy` is 0, `ctl_rdata` is zero and every flash word reads as all ones.
- R2: A start (`ctl_we` with `ctl_wdata[15]`=1 while idle) is accepted only when the two most recent key writes since the last start attempt were 0x55 and then 0xAA. Other register writes do not break the pair.
- R3: A key write of any other value, or 0xAA without a preceding 0x55, clears the unlock. A start attempted then is rejected: `busy` stays 0, `ctl_rdata[13]` becomes 1 and flash is unchanged.
- R4: Every start attempt uses up the unlock, whether it is accepted or not. A second start needs a new key pair.
- R5: An accepted start drives `busy` and `ctl_rdata[15]` to 1 from the next cycle for exactly ROW_CYC, WORD_CYC or ERASE_CYC cycles, depending on the operation. Both then clear by themselves.
- R6: `ctl_wdata[1:0]` selects the operation and reads back in `ctl_rdata[1:0]`: 01 word program, 10 row program, 11 page erase. A start with 00 is rejected and sets the error bit.
- R7: A row program copies buffer entries 0..63 into the 64 words of the row that contains `tgt_addr`. The low 6 address bits are ignored.
- R8: A word program writes buffer entry `tgt_addr[5:0]` to flash word `tgt_addr` only. Neighbouring words are unchanged.
- R9: A page erase sets all 512 words of the page that contains `tgt_addr` to all ones. Other pages are unchanged.
- R10: A buffer write stores `buf_wdata` at entry `buf_idx` and does not change flash or `busy`.
- R11: While `busy` is 1, writes to the buffer, key and control registers have no effect.
- R12: The error bit holds until a control write with bit 15 = 0 and bit 13 = 0 clears it. Any idle control write updates the operation field.
- R13: `rd_data` shows the flash word at `rd_addr` one cycle after `rd_addr` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control write data: [15] start, [13] error, [1:0] operation |
| tgt_addr | input | ADDR_W | Flash word address latched with an accepted start |
| key_we | input | 1 | Key register write strobe |
| key_data | input | 8 | Key value |
| buf_we | input | 1 | Holding buffer write strobe |
| buf_idx | input | 6 | Holding buffer entry |
| buf_wdata | input | WORD_W | Holding buffer data |
| rd_addr | input | ADDR_W | Flash read address |
| rd_data | output | WORD_W | Flash read data, one cycle of latency |
| ctl_rdata | output | 16 | Control readback: [15] running, [13] error, [1:0] operation |
| busy | output | 1 | Operation in progress |

## Verification
Several properties are checked on every cycle:
- `busy` rises only when the unlock was armed on the cycle before.
- A bad key write or any start attempt disarms the unlock.
- The latched operation and address hold steady for the whole run.
- Flash is written only while `busy` is 1, and never by a program and an erase in the same cycle.

Some behaviours need the bench's scenarios and its flash read-back:
- the exact length of each run;
- the rejection of broken, reversed and reused unlocks;
- the data written by row, word and erase operations, and the alignment of those writes;
- writes made during a run leaving no trace.

// File: rtl/nvm_pkg.sv
// Shared types and constants for the flash self-programming controller.
package nvm_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_WORD  = 2'b01,
        OP_ROW   = 2'b10,
        OP_ERASE = 2'b11
    } nvm_op_e;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;
    localparam int         START_BIT  = 15;
    localparam int         ERR_BIT    = 13;
endpackage

// File: rtl/nvm_unlock_fsm.sv
// Key-sequence tracker. It arms after a first-key write followed by a
// second-key write. Any other key value, or a start attempt (consume),
// disarms it. Assumes key_we is already gated off while an operation runs.
module nvm_unlock_fsm
    import nvm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_we,
    input  logic [7:0] key_data,
    input  logic       consume,
    output logic       armed
);
    typedef enum logic [1:0] {UL_IDLE, UL_HALF, UL_ARMED} ul_state_e;
    ul_state_e state_q;

    // Advance the key sequence; a start attempt has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= UL_IDLE;
        end else if (consume) begin
            state_q <= UL_IDLE;
        end else if (key_we) begin
            if (key_data == KEY_FIRST)
                state_q <= UL_HALF;
            else if (key_data == KEY_SECOND && state_q == UL_HALF)
                state_q <= UL_ARMED;
            else
                state_q <= UL_IDLE;
        end
    end

    assign armed = (state_q == UL_ARMED);

    // R3
    bad_key_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_we && !consume && key_data != KEY_SECOND) |=> !armed);
    // R4
    consume_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        consume |=> !armed);
endmodule

// File: rtl/nvm_holdbuf.sv
// Holding buffer for one row of program data. One write port, and one
// combinational read port used by the sequencer. Assumes the write
// strobe is already gated off while an operation runs.
module nvm_holdbuf #(
    parameter int WORD_W = 24,
    parameter int DEPTH  = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [WORD_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem_q [DEPTH];

    // Reset entries to the erased value; store a loaded word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else if (we) begin
            mem_q[widx] <= wdata;
        end
    end

    assign rdata = mem_q[ridx];
endmodule

// File: rtl/nvm_flash_array.sv
// Behavioural model of the flash array as a synchronous memory.
// One program port writes a word. One erase port sets a whole aligned
// page to ones. The read port is registered. Assumes program and erase
// never occur in the same cycle. The array comes out of reset erased.
module nvm_flash_array #(
    parameter int WORD_W     = 24,
    parameter int ADDR_W     = 11,
    parameter int PAGE_WORDS = 512,
    localparam int DEPTH     = 1 << ADDR_W,
    localparam int PG_LG     = $clog2(PAGE_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [WORD_W-1:0] prog_data,
    input  logic              erase_en,
    input  logic [ADDR_W-1:0] erase_addr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] mem_q [DEPTH];
    logic [ADDR_W-1:0] erase_base;

    assign erase_base = erase_addr >> PG_LG;

    // Update array contents: reset or erase to ones, else program.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else if (erase_en) begin
            for (int i = 0; i < DEPTH; i++)
                if ((ADDR_W'(i) >> PG_LG) == erase_base) mem_q[i] <= '1;
        end else if (prog_en) begin
            mem_q[prog_addr] <= prog_data;
        end
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '1;
        else        rd_data <= mem_q[rd_addr];
    end

    // R9
    erase_prog_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(erase_en && prog_en));
endmodule

// File: rtl/nvm_op_seq.sv
// Operation sequencer. It decodes control writes, accepts a start only
// when the unlock is armed and an operation is selected, and times the
// run with a down-counter. During a row run it streams the buffer into
// the row, one word per cycle. Assumes ROW_CYC >= ROW_WORDS and that
// every duration is at least 1.
module nvm_op_seq
    import nvm_pkg::*;
#(
    parameter int WORD_W    = 24,
    parameter int ADDR_W    = 11,
    parameter int ROW_WORDS = 64,
    parameter int ROW_CYC   = 11064,
    parameter int WORD_CYC  = 3600,
    parameter int ERASE_CYC = 20000,
    localparam int IDX_W    = $clog2(ROW_WORDS),
    localparam int MAX_CYC  = (ROW_CYC > WORD_CYC) ?
                              ((ROW_CYC > ERASE_CYC) ? ROW_CYC : ERASE_CYC) :
                              ((WORD_CYC > ERASE_CYC) ? WORD_CYC : ERASE_CYC),
    localparam int CNT_W    = $clog2(MAX_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [15:0]       ctl_wdata,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic              armed,
    input  logic [WORD_W-1:0] buf_rdata,
    output logic [IDX_W-1:0]  buf_ridx,
    output logic              consume,
    output logic              busy,
    output logic              err,
    output logic [1:0]        op_field,
    output logic              prog_en,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [WORD_W-1:0] prog_data,
    output logic              erase_en,
    output logic [ADDR_W-1:0] erase_addr
);
    nvm_op_e           op_q;
    logic              busy_q, err_q;
    logic [ADDR_W-1:0] tgt_q;
    logic [CNT_W-1:0]  cnt_q, dur_m1;
    logic [IDX_W:0]    step_q;
    logic              start_req, go, unused_ctl;
    nvm_op_e           new_op;

    assign unused_ctl = ^{ctl_wdata[14], ctl_wdata[12:2]};
    assign new_op     = nvm_op_e'(ctl_wdata[1:0]);
    assign start_req  = ctl_we && ctl_wdata[START_BIT] && !busy_q;
    assign go         = start_req && armed && (new_op != OP_NONE);
    assign consume    = start_req;

    // Pick the run length for the requested operation.
    always_comb begin
        case (new_op)
            OP_ROW:   dur_m1 = CNT_W'(ROW_CYC - 1);
            OP_WORD:  dur_m1 = CNT_W'(WORD_CYC - 1);
            OP_ERASE: dur_m1 = CNT_W'(ERASE_CYC - 1);
            default:  dur_m1 = '0;
        endcase
    end

    // Control register state, run timer and row step counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            err_q  <= 1'b0;
            op_q   <= OP_NONE;
            tgt_q  <= '0;
            cnt_q  <= '0;
            step_q <= '0;
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
            if (step_q < (IDX_W+1)'(ROW_WORDS)) step_q <= step_q + 1'b1;
        end else if (ctl_we) begin
            op_q <= new_op;
            if (ctl_wdata[START_BIT]) begin
                if (go) begin
                    busy_q <= 1'b1;
                    cnt_q  <= dur_m1;
                    tgt_q  <= tgt_addr;
                    step_q <= '0;
                end else begin
                    err_q <= 1'b1;
                end
            end else begin
                err_q <= err_q & ctl_wdata[ERR_BIT];
            end
        end
    end

    // Drive the flash ports from the active operation.
    always_comb begin
        buf_ridx   = (op_q == OP_ROW) ? step_q[IDX_W-1:0] : tgt_q[IDX_W-1:0];
        prog_en    = busy_q && (((op_q == OP_ROW) && step_q < (IDX_W+1)'(ROW_WORDS)) ||
                                ((op_q == OP_WORD) && step_q == '0));
        prog_addr  = (op_q == OP_ROW) ? {tgt_q[ADDR_W-1:IDX_W], step_q[IDX_W-1:0]} : tgt_q;
        prog_data  = buf_rdata;
        erase_en   = busy_q && (op_q == OP_ERASE) && step_q == '0;
        erase_addr = tgt_q;
    end

    assign busy     = busy_q;
    assign err      = err_q;
    assign op_field = op_q;

    // R2
    start_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> $past(armed));
    // R5
    op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q)) |-> ($stable(op_q) && $stable(tgt_q)));
    // R11
    busy_err_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> $stable(err_q));
endmodule

// File: rtl/nvm_selfprog_ctrl.sv
// Top of the flash self-programming controller. It gates the buffer and
// key write strobes while an operation runs, and connects the unlock
// tracker, the holding buffer, the sequencer and the flash array model.
module nvm_selfprog_ctrl
    import nvm_pkg::*;
#(
    parameter int WORD_W     = 24,
    parameter int ADDR_W     = 11,
    parameter int ROW_WORDS  = 64,
    parameter int PAGE_ROWS  = 8,
    parameter int ROW_CYC    = 11064,
    parameter int WORD_CYC   = 3600,
    parameter int ERASE_CYC  = 20000,
    localparam int IDX_W     = $clog2(ROW_WORDS),
    localparam int PAGE_WORDS = ROW_WORDS * PAGE_ROWS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [15:0]       ctl_wdata,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic              key_we,
    input  logic [7:0]        key_data,
    input  logic              buf_we,
    input  logic [IDX_W-1:0]  buf_idx,
    input  logic [WORD_W-1:0] buf_wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic [15:0]       ctl_rdata,
    output logic              busy
);
    logic              armed, consume, err;
    logic [1:0]        op_field;
    logic [IDX_W-1:0]  buf_ridx;
    logic [WORD_W-1:0] buf_rdata, prog_data;
    logic              prog_en, erase_en;
    logic [ADDR_W-1:0] prog_addr, erase_addr;
    logic              key_we_g, buf_we_g;

    assign key_we_g = key_we && !busy;
    assign buf_we_g = buf_we && !busy;

    nvm_unlock_fsm u_unlock (
        .clk(clk), .rst_n(rst_n), .key_we(key_we_g), .key_data(key_data),
        .consume(consume), .armed(armed)
    );

    nvm_holdbuf #(.WORD_W(WORD_W), .DEPTH(ROW_WORDS)) u_buf (
        .clk(clk), .rst_n(rst_n), .we(buf_we_g), .widx(buf_idx),
        .wdata(buf_wdata), .ridx(buf_ridx), .rdata(buf_rdata)
    );

    nvm_op_seq #(
        .WORD_W(WORD_W), .ADDR_W(ADDR_W), .ROW_WORDS(ROW_WORDS),
        .ROW_CYC(ROW_CYC), .WORD_CYC(WORD_CYC), .ERASE_CYC(ERASE_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .tgt_addr(tgt_addr), .armed(armed), .buf_rdata(buf_rdata),
        .buf_ridx(buf_ridx), .consume(consume), .busy(busy), .err(err),
        .op_field(op_field), .prog_en(prog_en), .prog_addr(prog_addr),
        .prog_data(prog_data), .erase_en(erase_en), .erase_addr(erase_addr)
    );

    nvm_flash_array #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .PAGE_WORDS(PAGE_WORDS)) u_flash (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .prog_addr(prog_addr),
        .prog_data(prog_data), .erase_en(erase_en), .erase_addr(erase_addr),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // Control readback: running, error and operation fields.
    always_comb begin
        ctl_rdata            = '0;
        ctl_rdata[START_BIT] = busy;
        ctl_rdata[ERR_BIT]   = err;
        ctl_rdata[1:0]       = op_field;
    end

    // R10
    flash_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en || erase_en) |-> busy);
endmodule

// File: tb/test_nvm_selfprog_ctrl.sv
// Bench: a behavioural reference model, updated on each rising edge and
// compared with the outputs on every falling edge. Flash contents are
// checked through the read port.
module test_nvm_selfprog_ctrl;
    localparam int WW = 24, AW = 11, RC = 80, WC = 30, EC = 100;

    logic clk = 0, rst_n = 0;
    logic ctl_we = 0, key_we = 0, buf_we = 0;
    logic [15:0] ctl_wdata = 0;
    logic [AW-1:0] tgt_addr = 0, rd_addr = 0;
    logic [7:0] key_data = 0;
    logic [5:0] buf_idx = 0;
    logic [WW-1:0] buf_wdata = 0, rd_data;
    logic [15:0] ctl_rdata;
    logic busy;

    int checks = 0, failures = 0, cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;

    nvm_selfprog_ctrl #(.ROW_CYC(RC), .WORD_CYC(WC), .ERASE_CYC(EC)) i_nvm_selfprog_ctrl (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .tgt_addr(tgt_addr), .key_we(key_we), .key_data(key_data),
        .buf_we(buf_we), .buf_idx(buf_idx), .buf_wdata(buf_wdata),
        .rd_addr(rd_addr), .rd_data(rd_data), .ctl_rdata(ctl_rdata), .busy(busy)
    );

    // Reference model state.
    logic [WW-1:0] fm [2048];
    logic [WW-1:0] bm [64];
    int  m_ul, m_rem, m_op;
    bit  m_busy, m_err;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ul = 0; m_rem = 0; m_op = 0; m_busy = 0; m_err = 0;
            foreach (fm[i]) fm[i] = '1;
            foreach (bm[i]) bm[i] = '1;
        end else if (m_busy) begin
            m_rem--;
            if (m_rem == 0) m_busy = 0;
        end else begin
            bit attempt;
            attempt = ctl_we && ctl_wdata[15];
            if (buf_we) bm[buf_idx] = buf_wdata;
            if (ctl_we) begin
                m_op = ctl_wdata[1:0];
                if (attempt) begin
                    if (m_ul == 2 && m_op != 0) begin
                        int base;
                        m_busy = 1;
                        if (m_op == 2) begin
                            m_rem = RC; base = (tgt_addr / 64) * 64;
                            for (int k = 0; k < 64; k++) fm[base + k] = bm[k];
                        end else if (m_op == 1) begin
                            m_rem = WC; fm[tgt_addr] = bm[tgt_addr % 64];
                        end else begin
                            m_rem = EC; base = (tgt_addr / 512) * 512;
                            for (int k = 0; k < 512; k++) fm[base + k] = '1;
                        end
                    end else m_err = 1;
                end else if (!ctl_wdata[13]) m_err = 0;
            end
            if (attempt) m_ul = 0;
            else if (key_we) begin
                if (key_data == 8'h55) m_ul = 1;
                else if (key_data == 8'hAA && m_ul == 1) m_ul = 2;
                else m_ul = 0;
            end
        end
    end

    // Per-cycle comparison of busy and control readback (R1, R5, R6, R12).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [15:0] exp;
            exp = 16'(m_op);
            exp[15] = m_busy;
            exp[13] = m_err;
            checks++;
            if (busy !== m_busy || ctl_rdata !== exp) begin
                failures++;
                $display("FAIL R5/R6/R12 cycle %0d: busy=%0b ctl=%h expected busy=%0b ctl=%h",
                         cyc, busy, ctl_rdata, m_busy, exp);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic key_wr(input logic [7:0] v);
        @(negedge clk); key_we = 1; key_data = v;
        @(negedge clk); key_we = 0;
    endtask

    task automatic ctl_wr(input logic [15:0] v, input logic [AW-1:0] a);
        @(negedge clk); ctl_we = 1; ctl_wdata = v; tgt_addr = a;
        @(negedge clk); ctl_we = 0;
    endtask

    task automatic buf_wr(input int idx, input logic [WW-1:0] d);
        @(negedge clk); buf_we = 1; buf_idx = 6'(idx); buf_wdata = d;
        @(negedge clk); buf_we = 0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    // Read one flash word and compare with the model (R13 latency).
    task automatic chk_flash(input int a, input string tag);
        @(negedge clk); rd_addr = AW'(a);
        @(negedge clk);
        checks++;
        if (rd_data !== fm[a]) begin
            failures++;
            $display("FAIL %s flash[%0h]: got %h expected %h", tag, a, rd_data, fm[a]);
        end
    endtask

    task automatic chk_bit(input bit act, input bit exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: erased after reset.
        chk_flash(0, "R1");
        chk_flash(2047, "R1");
        chk_bit(busy, 0, "R1 busy");

        // R10: buffer loads do not touch flash.
        for (int k = 0; k < 64; k++) buf_wr(k, 24'h100000 + 24'(k * 3));
        chk_bit(busy, 0, "R10 busy");
        chk_flash(8'hC0, "R10");

        // R2, R7: row program at an unaligned address in row 3.
        key_wr(8'h55); key_wr(8'hAA);
        ctl_wr(16'h8002, 11'h0C5);
        chk_bit(busy, 1, "R2 busy");
        wait_idle();
        chk_flash(11'h0C0, "R7");
        chk_flash(11'h0C5, "R7");
        chk_flash(11'h0FF, "R7");
        chk_flash(11'h100, "R7 next row");

        // R8: word program.
        buf_wr(7, 24'hABCDEF);
        key_wr(8'h55); key_wr(8'hAA);
        ctl_wr(16'h8001, 11'h207);
        wait_idle();
        chk_flash(11'h206, "R8");
        chk_flash(11'h207, "R8");
        chk_flash(11'h208, "R8");

        // R9: page erase of page 0 leaves page 1 alone.
        key_wr(8'h55); key_wr(8'hAA);
        ctl_wr(16'h8003, 11'h0D0);
        wait_idle();
        chk_flash(11'h0C0, "R9");
        chk_flash(11'h0FF, "R9");
        chk_flash(11'h207, "R9 other page");

        // R3: wrong second key.
        key_wr(8'h55); key_wr(8'hAB);
        ctl_wr(16'h8002, 11'h000);
        chk_bit(busy, 0, "R3 busy");
        chk_bit(ctl_rdata[13], 1, "R3 err");
        chk_flash(11'h000, "R3");
        // R12: clear error.
        ctl_wr(16'h0002, 11'h000);
        chk_bit(ctl_rdata[13], 0, "R12 clear");
        // R3: reversed order.
        key_wr(8'hAA); key_wr(8'h55);
        ctl_wr(16'h8002, 11'h000);
        chk_bit(busy, 0, "R3 reversed");
        ctl_wr(16'h2001, 11'h000);
        chk_bit(ctl_rdata[13], 1, "R12 sticky");
        ctl_wr(16'h0000, 11'h000);

        // R6, R4: start with op 00 rejected, unlock then used up.
        key_wr(8'h55); key_wr(8'hAA);
        ctl_wr(16'h8000, 11'h000);
        chk_bit(busy, 0, "R6 op none");
        chk_bit(ctl_rdata[13], 1, "R6 err");
        ctl_wr(16'h0000, 11'h000);
        ctl_wr(16'h8002, 11'h000);
        chk_bit(busy, 0, "R4 reuse");
        ctl_wr(16'h0000, 11'h000);

        // R11: writes during a run are ignored.
        key_wr(8'h55); key_wr(8'hAA);
        ctl_wr(16'h8001, 11'h300);
        buf_wr(0, 24'h000111);
        key_wr(8'h55); key_wr(8'hAA);
        ctl_wr(16'h0000, 11'h000);
        wait_idle();
        ctl_wr(16'h8002, 11'h340);
        chk_bit(busy, 0, "R11 keys ignored");
        ctl_wr(16'h0000, 11'h000);
        key_wr(8'h55); key_wr(8'hAA);
        ctl_wr(16'h8002, 11'h340);
        wait_idle();
        chk_flash(11'h340, "R11 buffer kept");
        chk_flash(11'h300, "R8 word");

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule